// File: doc/BRIEF.md
# Open-Page SDRAM Access Controller

This block connects one internal bus master to one SDRAM device and keeps the most recently used row open between accesses. A request is accepted over a valid/ready handshake. The accepting cycle puts out the address. The next cycle always compares the requested row against the stored open row. On a page hit, the read or write command goes out immediately. On a page miss with another row open, the controller precharges, activates the new row and waits the programmed activate-to-command delay. When no row is open, the precharge step is left out.

Accesses are either single transfers or 16-byte line bursts. A burst is four beats on a 32-bit data port and eight beats on a 16-bit port. One read or write command is issued per beat, with the column advancing each beat. Read data is marked by a per-beat valid strobe that follows each read command by the CAS latency. The controller issues periodic auto-refresh on its own, closing any open row first. It also enters and leaves power-down and self-refresh, and these drive the clock enable low. An enable input switches the whole controller off.

The state machine has these states. IDLE waits for work. DECIDE is the hit/miss cycle. PRE holds the precharge time. ACT issues the activate. RCD holds the activate wait. XFER issues the beats. REF issues the auto-refresh. PDN holds power-down. SLF holds self-refresh.

The transitions are as follows:
- IDLE goes to PRE or REF when a refresh is due, to PRE or SLF on a self-refresh request, to PDN on a power-down request, and to DECIDE when a request is accepted.
- DECIDE goes to XFER on a hit, to PRE on a miss with a row open, and to ACT on a miss with no row open.
- PRE goes on to ACT, REF or SLF, depending on what it was entered for.
- ACT goes to RCD, or straight to XFER when the delay is zero.
- RCD goes to XFER.
- XFER goes to IDLE after the last beat.
- REF goes to IDLE.
- PDN and SLF go to IDLE when their request is released.

Top module: `sdram_page_ctrl`

## Requirements
- R1: Command codes on sd_cmd are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5, SRE=6. After reset the controller is idle with sd_cke high, sd_cmd NOP, rd_valid low and req_ready high.
- R2: On a page hit (a row is open and its address equals req_row), the first RD or WR command appears in the second cycle after the accepting clock edge, and no PRE or ACT is issued.
- R3: On a miss with no open row, ACT with sd_row equal to the request row appears in the second cycle after acceptance, and the first RD/WR follows cfg_rcd cycles after the cycle after ACT.
- R4: On a miss with another row open, PRE appears in the second cycle after acceptance. ACT follows max(cfg_rp,1) cycles after PRE.
- R5: With cfg_rcd equal to 0, the first RD/WR comes in the cycle directly after ACT.
- R6: A single access issues one RD/WR. A burst issues 4 (cfg_wide=1) or 8 (cfg_wide=0) commands in consecutive cycles, with sd_col starting at req_col and rising by one each beat, modulo the column width.
- R7: rd_valid pulses once per RD command, exactly CAS_LAT (2) cycles after it, and never for writes.
- R8: Every REF_PERIOD enabled cycles a refresh becomes due. From idle, the controller then precharges any open row and issues REF, and no row is open afterwards. req_ready stays low while a refresh is due.
- R9: While pd_req is held in idle, sd_cke is low, only NOP is issued and req_ready is low. The open row survives power-down.
- R10: On sr_req the open row is precharged, then SRE is issued with sd_cke low. sd_cke stays low until sr_req is released, and no row is open after exit.
- R11: While ctl_en is low, req_ready is low, no command is issued and the refresh timer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and SDRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_en | input | 1 | Controller enable |
| cfg_wide | input | 1 | 1: 32-bit data port, 0: 16-bit |
| cfg_rp | input | 2 | Precharge cycles (0 treated as 1) |
| cfg_rcd | input | 2 | Wait cycles after ACT |
| pd_req | input | 1 | Power-down request (level) |
| sr_req | input | 1 | Self-refresh request (level) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1: write, 0: read |
| req_burst | input | 1 | 1: 16-byte line, 0: single |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Start column |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cmd | output | 3 | SDRAM command code |
| sd_row | output | ROW_W | Row address for ACT |
| sd_col | output | COL_W | Column address for RD/WR |
| rd_valid | output | 1 | Read beat valid strobe |

## Verification
The hardest situation to reach from the ports is a refresh or self-refresh that lands while a row is open. It has to be seen as PRE first and then REF or SRE, and then as a miss on the next access to that same row. The stimulus first leaves a known row open with a hit access. It then either raises sr_req or waits idle for the refresh timer. Finally it requests the same row again and expects the closed-miss latency instead of the hit latency. A row-dependent table of accesses walks through hits, open misses, closed misses, both port widths and every precharge and activate delay setting, including a column wrap during a burst.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_SRE = 3'd6
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DECIDE, ST_PRE, ST_ACT, ST_RCD,
        ST_XFER, ST_REF, ST_PDN, ST_SLF
    } ctl_state_e;

    typedef enum logic [1:0] {
        AFT_ACT, AFT_REF, AFT_SLF
    } pre_next_e;
endpackage

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
    parameter int PERIOD = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic clr,
    output logic pend
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            pend  <= 1'b0;
        end else begin
            if (clr)
                pend <= 1'b0;
            if (hold) begin
                count <= '0;
            end else if (count == CW'(PERIOD - 1)) begin
                count <= '0;
                pend  <= 1'b1;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    p_pend_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);
endmodule

// File: rtl/sdc_open_row.sv
module sdc_open_row #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic             close,
    input  logic [ROW_W-1:0] row_in,
    output logic             hit,
    output logic             row_valid
);
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_valid <= 1'b0;
            row_q     <= '0;
        end else if (close) begin
            row_valid <= 1'b0;
        end else if (open_set) begin
            row_valid <= 1'b1;
            row_q     <= row_in;
        end
    end

    assign hit = row_valid && (row_q == row_in);

    p_set_close_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_set && close));
endmodule

// File: rtl/sdram_page_ctrl.sv
module sdram_page_ctrl
    import sdc_pkg::*;
#(
    parameter int ROW_W      = 12,
    parameter int COL_W      = 9,
    parameter int LINE_BYTES = 16,
    parameter int CAS_LAT    = 2,
    parameter int REF_PERIOD = 780
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_en,
    input  logic             cfg_wide,
    input  logic [1:0]       cfg_rp,
    input  logic [1:0]       cfg_rcd,
    input  logic             pd_req,
    input  logic             sr_req,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic             req_burst,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             sd_cke,
    output logic [2:0]       sd_cmd,
    output logic [ROW_W-1:0] sd_row,
    output logic [COL_W-1:0] sd_col,
    output logic             rd_valid
);
    localparam int BEATS_N = LINE_BYTES / 2;
    localparam int BEATS_W = LINE_BYTES / 4;
    localparam int BT_W    = $clog2(BEATS_N) + 1;

    ctl_state_e       st, st_nx;
    pre_next_e        aft_q, aft_nx;
    sd_cmd_e          cmd;
    logic [3:0]       cnt;
    logic [BT_W-1:0]  beat, beats_total;
    logic             lat_wr, lat_burst, lat_wide;
    logic [ROW_W-1:0] lat_row;
    logic [COL_W-1:0] lat_col;
    logic [1:0]       rp_eff;
    logic             ref_pend, row_hit, row_valid, accept, last_beat;
    logic [CAS_LAT-1:0] rd_pipe;

    sdc_refresh_timer #(.PERIOD(REF_PERIOD)) u_ref (
        .clk(clk), .rst_n(rst_n),
        .hold(!ctl_en || st == ST_SLF),
        .clr(st == ST_REF || st == ST_SLF),
        .pend(ref_pend)
    );

    sdc_open_row #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n),
        .open_set(st == ST_ACT),
        .close(st == ST_PRE && cnt == 4'd0),
        .row_in(lat_row),
        .hit(row_hit), .row_valid(row_valid)
    );

    assign rp_eff      = (cfg_rp == 2'd0) ? 2'd1 : cfg_rp;
    assign beats_total = !lat_burst ? BT_W'(1) : (lat_wide ? BT_W'(BEATS_W) : BT_W'(BEATS_N));
    assign last_beat   = (beat + 1'b1) == beats_total;
    assign accept      = req_valid && req_ready;

    // next-state logic
    always_comb begin
        st_nx  = st;
        aft_nx = aft_q;
        unique case (st)
            ST_IDLE: begin
                if (ctl_en) begin
                    if (ref_pend) begin
                        st_nx  = row_valid ? ST_PRE : ST_REF;
                        aft_nx = AFT_REF;
                    end else if (sr_req) begin
                        st_nx  = row_valid ? ST_PRE : ST_SLF;
                        aft_nx = AFT_SLF;
                    end else if (pd_req) begin
                        st_nx = ST_PDN;
                    end else if (req_valid) begin
                        st_nx = ST_DECIDE;
                    end
                end
            end
            ST_DECIDE: begin
                if (row_hit) begin
                    st_nx = ST_XFER;
                end else if (row_valid) begin
                    st_nx  = ST_PRE;
                    aft_nx = AFT_ACT;
                end else begin
                    st_nx = ST_ACT;
                end
            end
            ST_PRE: begin
                if (cnt == {2'b00, rp_eff - 2'd1}) begin
                    unique case (aft_q)
                        AFT_ACT: st_nx = ST_ACT;
                        AFT_REF: st_nx = ST_REF;
                        default: st_nx = ST_SLF;
                    endcase
                end
            end
            ST_ACT:  st_nx = (cfg_rcd == 2'd0) ? ST_XFER : ST_RCD;
            ST_RCD:  if (cnt == {2'b00, cfg_rcd - 2'd1}) st_nx = ST_XFER;
            ST_XFER: if (last_beat) st_nx = ST_IDLE;
            ST_REF:  st_nx = ST_IDLE;
            ST_PDN:  if (!pd_req) st_nx = ST_IDLE;
            ST_SLF:  if (!sr_req) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register and sequencing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            aft_q     <= AFT_ACT;
            cnt       <= '0;
            beat      <= '0;
            lat_wr    <= 1'b0;
            lat_burst <= 1'b0;
            lat_wide  <= 1'b0;
            lat_row   <= '0;
            lat_col   <= '0;
            rd_pipe   <= '0;
        end else begin
            st    <= st_nx;
            aft_q <= aft_nx;
            if (st_nx != st)
                cnt <= '0;
            else if (cnt != 4'hF)
                cnt <= cnt + 1'b1;
            beat <= (st == ST_XFER) ? beat + 1'b1 : '0;
            if (accept) begin
                lat_wr    <= req_write;
                lat_burst <= req_burst;
                lat_wide  <= cfg_wide;
                lat_row   <= req_row;
                lat_col   <= req_col;
            end
            rd_pipe <= (rd_pipe << 1) | CAS_LAT'(st == ST_XFER && !lat_wr);
        end
    end

    // outputs
    always_comb begin
        cmd       = CMD_NOP;
        sd_cke    = 1'b1;
        req_ready = 1'b0;
        unique case (st)
            ST_IDLE: req_ready = ctl_en && !ref_pend && !sr_req && !pd_req;
            ST_PRE:  cmd = (cnt == 4'd0) ? CMD_PRE : CMD_NOP;
            ST_ACT:  cmd = CMD_ACT;
            ST_XFER: cmd = lat_wr ? CMD_WR : CMD_RD;
            ST_REF:  cmd = CMD_REF;
            ST_PDN:  sd_cke = 1'b0;
            ST_SLF: begin
                sd_cke = 1'b0;
                cmd    = (cnt == 4'd0) ? CMD_SRE : CMD_NOP;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign sd_cmd   = cmd;
    assign sd_row   = lat_row;
    assign sd_col   = lat_col + COL_W'(beat);
    assign rd_valid = rd_pipe[CAS_LAT-1];

    p_cke_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cke |-> (sd_cmd == CMD_NOP || sd_cmd == CMD_SRE));
    p_xfer_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_RD || sd_cmd == CMD_WR) |-> row_valid);
    p_act_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_ACT) |-> !row_valid);
    p_ref_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_REF) |-> !row_valid);
    p_ref_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready);
    p_sre_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_SRE) |-> !row_valid);
    p_off_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> !req_ready);
endmodule

// File: tb/sim_sdram_page_ctrl.sv
module sim_sdram_page_ctrl;
    localparam int ROW_W = 4;
    localparam int COL_W = 4;
    localparam int REFP  = 2000;
    localparam int TW    = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_en = 1'b1, cfg_wide = 1'b0, pd_req = 1'b0, sr_req = 1'b0;
    logic [1:0] cfg_rp = 2'd2, cfg_rcd = 2'd1;
    logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic req_ready, sd_cke, rd_valid;
    logic [2:0] sd_cmd;
    logic [ROW_W-1:0] sd_row;
    logic [COL_W-1:0] sd_col;

    int n_chk = 0, n_bad = 0;
    logic [2:0]       tr_cmd [TW];
    logic [ROW_W-1:0] tr_row [TW];
    logic [COL_W-1:0] tr_col [TW];
    logic             tr_rdv [TW];

    always #2 clk = ~clk;

    sdram_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .LINE_BYTES(16),
                      .CAS_LAT(2), .REF_PERIOD(REFP)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .cfg_wide(cfg_wide),
        .cfg_rp(cfg_rp), .cfg_rcd(cfg_rcd), .pd_req(pd_req), .sr_req(sr_req),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_burst(req_burst), .req_row(req_row), .req_col(req_col),
        .sd_cke(sd_cke), .sd_cmd(sd_cmd), .sd_row(sd_row), .sd_col(sd_col),
        .rd_valid(rd_valid)
    );

    // vector: wr, burst, wide, row, col, rp, rcd, expected latency, expects PRE
    localparam logic [19:0] VEC [12] = '{
        {1'b0, 1'b0, 1'b0, 4'd3,  4'd2,  2'd2, 2'd1, 4'd4, 1'b0},
        {1'b0, 1'b0, 1'b0, 4'd3,  4'd5,  2'd2, 2'd1, 4'd2, 1'b0},
        {1'b1, 1'b1, 1'b1, 4'd3,  4'd0,  2'd2, 2'd1, 4'd2, 1'b0},
        {1'b0, 1'b1, 1'b0, 4'd3,  4'd8,  2'd2, 2'd1, 4'd2, 1'b0},
        {1'b0, 1'b0, 1'b0, 4'd7,  4'd1,  2'd2, 2'd1, 4'd6, 1'b1},
        {1'b1, 1'b0, 1'b0, 4'd7,  4'd3,  2'd2, 2'd1, 4'd2, 1'b0},
        {1'b0, 1'b1, 1'b1, 4'd9,  4'd4,  2'd3, 2'd0, 4'd6, 1'b1},
        {1'b0, 1'b0, 1'b0, 4'd9,  4'd6,  2'd0, 2'd2, 4'd2, 1'b0},
        {1'b1, 1'b1, 1'b0, 4'd0,  4'd0,  2'd0, 2'd0, 4'd4, 1'b1},
        {1'b0, 1'b0, 1'b0, 4'd0,  4'd9,  2'd1, 2'd1, 4'd2, 1'b0},
        {1'b0, 1'b0, 1'b0, 4'd15, 4'd3,  2'd1, 2'd3, 4'd7, 1'b1},
        {1'b1, 1'b1, 1'b1, 4'd15, 4'd14, 2'd1, 2'd3, 4'd2, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_req(input logic wr, input logic bu, input logic wi,
                           input logic [3:0] row, input logic [3:0] col,
                           input logic [1:0] rp, input logic [1:0] rcd,
                           input int exp_lat, input logic exp_pre);
        int fx, npre, nact, arow, nbeat, nrdv, frdv, exp_beats;
        string tag;
        @(negedge clk);
        cfg_wide = wi; cfg_rp = rp; cfg_rcd = rcd;
        req_write = wr; req_burst = bu; req_row = row; req_col = col;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
        for (int i = 1; i < TW; i++) begin
            @(negedge clk);
            tr_cmd[i] = sd_cmd; tr_row[i] = sd_row;
            tr_col[i] = sd_col; tr_rdv[i] = rd_valid;
        end
        fx = 0; npre = 0; nact = 0; arow = -1;
        for (int i = TW - 1; i >= 1; i--)
            if (tr_cmd[i] == 3'd2 || tr_cmd[i] == 3'd3) fx = i;
        for (int i = 1; i < TW; i++) begin
            if (tr_cmd[i] == 3'd4) npre++;
            if (tr_cmd[i] == 3'd1) begin nact++; arow = int'(tr_row[i]); end
        end
        if (exp_lat != 2 && rcd == 2'd0) tag = "R5";
        else if (exp_pre) tag = "R4";
        else if (exp_lat != 2) tag = "R3";
        else tag = "R2";
        chk({tag, " first command latency"}, fx, exp_lat);
        chk({tag, " PRE count"}, npre, exp_pre ? 1 : 0);
        chk({tag, " ACT count"}, nact, (exp_lat != 2) ? 1 : 0);
        if (exp_lat != 2) chk("R3 ACT row", arow, int'(row));
        exp_beats = !bu ? 1 : (wi ? 4 : 8);
        nbeat = 0;
        for (int i = fx; i < TW && fx > 0; i++) begin
            if (tr_cmd[i] != (wr ? 3'd3 : 3'd2)) break;
            if (int'(tr_col[i]) != ((int'(col) + nbeat) % 16))
                chk("R6 beat column", int'(tr_col[i]), (int'(col) + nbeat) % 16);
            nbeat++;
        end
        chk("R6 beat count", nbeat, exp_beats);
        nrdv = 0; frdv = 0;
        for (int i = TW - 1; i >= 1; i--)
            if (tr_rdv[i]) begin nrdv++; frdv = i; end
        chk("R7 read valid count", nrdv, wr ? 0 : exp_beats);
        if (!wr) chk("R7 read valid timing", frdv, fx + 2);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k, pre_at, ref_at;
        logic ok;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cke after reset", int'(sd_cke), 1);
        chk("R1 cmd after reset", int'(sd_cmd), 0);
        chk("R1 rd_valid after reset", int'(rd_valid), 0);
        chk("R1 ready after reset", int'(req_ready), 1);

        foreach (VEC[i])
            run_req(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:13],
                    VEC[i][12:9], VEC[i][8:7], VEC[i][6:5],
                    int'(VEC[i][4:1]), VEC[i][0]);

        // R11 disabled controller
        @(negedge clk);
        ctl_en = 1'b0; req_valid = 1'b1;
        ok = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (req_ready || sd_cmd != 3'd0) ok = 1'b0;
        end
        chk("R11 disabled idle", int'(ok), 1);
        req_valid = 1'b0; ctl_en = 1'b1;

        // R9 power-down keeps row 15 open
        @(negedge clk);
        pd_req = 1'b1;
        @(negedge clk);
        ok = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (sd_cke || req_ready || sd_cmd != 3'd0) ok = 1'b0;
        end
        chk("R9 power-down quiet", int'(ok), 1);
        pd_req = 1'b0;
        @(negedge clk);
        chk("R9 cke after exit", int'(sd_cke), 1);
        run_req(1'b0, 1'b0, 1'b0, 4'd15, 4'd1, 2'd1, 2'd1, 2, 1'b0);

        // R10 self-refresh closes row
        @(negedge clk);
        sr_req = 1'b1;
        pre_at = 0; ref_at = 0; ok = 1'b1;
        for (int i = 1; i < 10; i++) begin
            @(negedge clk);
            if (sd_cmd == 3'd4 && pre_at == 0) pre_at = i;
            if (sd_cmd == 3'd6) begin ref_at = i; if (sd_cke) ok = 1'b0; end
        end
        chk("R10 PRE before SRE", int'(pre_at > 0 && ref_at > pre_at), 1);
        chk("R10 cke low during SRE", int'(ok), 1);
        chk("R10 cke held low", int'(sd_cke), 0);
        sr_req = 1'b0;
        @(negedge clk);
        chk("R10 cke after exit", int'(sd_cke), 1);
        run_req(1'b0, 1'b0, 1'b0, 4'd15, 4'd2, 2'd1, 2'd1, 4, 1'b0);

        // R8 periodic refresh closes row 15
        pre_at = -1; ref_at = -1; k = 0;
        while (ref_at < 0 && k < REFP + 200) begin
            @(negedge clk);
            k++;
            if (sd_cmd == 3'd4) pre_at = k;
            if (sd_cmd == 3'd5) ref_at = k;
        end
        chk("R8 refresh issued", int'(ref_at > 0), 1);
        chk("R8 PRE before REF", int'(pre_at > 0 && pre_at < ref_at), 1);
        run_req(1'b0, 1'b0, 1'b0, 4'd15, 4'd3, 2'd1, 2'd1, 4, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule